// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block picks instructions for issue each cycle. Each operation class has its own ready queue, and the block picks the oldest instruction first across all classes. An instruction arrives on a single push port with its class code, a sequence number and a squashed flag. Inside each class, the entry with the lowest sequence number is the candidate. The non-empty classes are ranked by the age of their candidates. The selector walks that ranking and asks the matching functional unit for a slot. It stops when the issue width is used up, when the downstream stage refuses work, or when every class has been visited.

A class whose unit is busy is passed over and counted as a busy event. Younger classes behind it can still issue. Single-cycle operations go straight to the execute lanes. Multi-cycle operations are parked in completion slots and come out on the same lanes when their latency has run. A unit release is reported one cycle after issue for pipelined and single-cycle work. For unpipelined work it is reported in the cycle the operation completes. Completions always take lanes ahead of new issues. Class code `NUM_CLASSES` means "needs no functional unit".

Top module: `issue_selector`

## Requirements
- R1: After reset no execute lane is valid, every unit release count is zero and the busy-event count is zero.
- R2: The ranking is by the head sequence number of each class, compared unsigned. Issued instructions fill lanes in ascending sequence order, starting at the first lane after any completions.
- R3: Within a class the lowest sequence number is issued first. At most one instruction per class issues per cycle. The rest stay for later cycles in ascending order.
- R4: No more than `ISSUE_W` instructions are issued per cycle, and this count includes multi-cycle issues. While `can_issue_i` is low nothing new is issued and no busy event is counted, but completions still appear.
- R5: A squashed head is dropped when the walk reaches it. It uses no lane and no width, and later classes may use that width in the same cycle.
- R6: A class whose `unit_free_i` bit is low is skipped and adds one to `busy_cnt_o` (visible the next cycle). Younger classes behind it still issue in that cycle.
- R7: Class code 3 (`NUM_CLASSES` at default parameters) issues whatever `unit_free_i` says. It is single-cycle and never produces a unit release.
- R8: For a class with latency field 0 or 1, the issued instruction appears on a lane in the issue cycle. That class's 2-bit release count in `unit_release_o` is 1 in the following cycle.
- R9: For a class with latency L ≥ 2, the instruction appears on a lane L−1 cycles after its issue cycle. Its release comes in the cycle after issue if `unpiped_i` for that class is 0, and in the completion cycle if it is 1.
- R10: Completions take the lowest lanes first, and each one reduces the number of new issues allowed in that cycle by one.
- R11: An instruction pushed into a class with a lower sequence number than the current head becomes the new head from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_vld_i | input | 1 | Push a ready instruction this cycle |
| push_cls_i | input | CLS_W | Class code of pushed instruction (NUM_CLASSES = no unit) |
| push_seq_i | input | SEQ_W | Sequence number of pushed instruction |
| push_sq_i | input | 1 | Pushed instruction is squashed |
| unit_free_i | input | NUM_CLASSES | Per-class functional unit available |
| op_lat_i | input | NUM_CLASSES*LAT_W | Per-class latency, class c at bits [c*LAT_W +: LAT_W] |
| unpiped_i | input | NUM_CLASSES | Per-class unpipelined flag |
| can_issue_i | input | 1 | Downstream accepts new issues |
| exe_vld_o | output | ISSUE_W | Execute lane valid |
| exe_seq_o | output | ISSUE_W*SEQ_W | Lane sequence numbers, lane l at [l*SEQ_W +: SEQ_W] |
| exe_cls_o | output | ISSUE_W*CLS_W | Lane class codes |
| unit_release_o | output | NUM_CLASSES*2 | Per-class count of units to release this cycle |
| busy_cnt_o | output | CNT_W | Running count of busy-unit skips |

## Verification
A table of three-class scenarios changes the relative age of the class heads, the unit-free mask and the downstream ready signal. This separates true age ranking (R2) from class-index priority, and separates skipping (R6) from stalling (R4). Directed cases then cover the remaining situations. A squashed head that is followed by live work shows whether the dropped entry takes a lane. Out-of-order pushes into one class show the head reordering and the one-per-class limit. The no-unit class is issued with every unit busy. Pipelined and unpipelined multi-cycle classes show that completion timing and release timing are distinct. A completion that lands on a cycle with two ready instructions shows the lane priority and the reduced issue budget.

// File: rtl/issel_pkg.sv
package issel_pkg;
  // outcome of visiting one class during the walk
  typedef enum logic [2:0] {
    VIS_NONE,
    VIS_DROP,
    VIS_ISSUE,
    VIS_BUSY,
    VIS_HOLD
  } visit_e;
endpackage

// File: rtl/issel_rdyq.sv
module issel_rdyq #(
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SEQ_W-1:0] push_seq_i,
  input  logic             push_sq_i,
  input  logic             pop_i,
  output logic             head_vld_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic             head_sq_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
  logic [DEPTH-1:0]            sq_q;
  logic [IDX_W-1:0]            head_idx, free_idx;
  logic                        free_ok;

  always_comb begin
    head_vld_o = 1'b0;
    head_seq_o = '0;
    head_sq_o  = 1'b0;
    head_idx   = '0;
    free_ok    = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && (!head_vld_o || seq_q[i] < head_seq_o)) begin
        head_vld_o = 1'b1;
        head_seq_o = seq_q[i];
        head_sq_o  = sq_q[i];
        head_idx   = IDX_W'(i);
      end
      if (!vld_q[i] && !free_ok) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      seq_q <= '0;
      sq_q  <= '0;
    end else begin
      if (pop_i && head_vld_o) vld_q[head_idx] <= 1'b0;
      if (push_i && free_ok) begin
        vld_q[free_idx] <= 1'b1;
        seq_q[free_idx] <= push_seq_i;
        sq_q[free_idx]  <= push_sq_i;
      end
    end
  end
endmodule

// File: rtl/issel_pick.sv
module issel_pick
  import issel_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 3,
  parameter int unsigned NQ          = NUM_CLASSES + 1,
  parameter int unsigned CLS_W       = 2,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned LAT_W       = 3,
  parameter int unsigned NSLOT       = 4,
  parameter int unsigned LW          = 2,
  parameter int unsigned BW          = 3
) (
  input  logic [NQ-1:0]                 head_vld_i,
  input  logic [NQ-1:0][SEQ_W-1:0]      head_seq_i,
  input  logic [NQ-1:0]                 head_sq_i,
  input  logic [NQ-1:0]                 free_ext_i,
  input  logic [NQ-1:0][LAT_W-1:0]      lat_ext_i,
  input  logic [NQ-1:0]                 unp_ext_i,
  input  logic                          can_issue_i,
  input  logic [LW-1:0]                 budget_i,
  input  logic [NSLOT-1:0]              slot_free_i,
  output logic [NQ-1:0]                 pop_o,
  output logic [LW-1:0]                 iss_n_o,
  output logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq_o,
  output logic [ISSUE_W-1:0][CLS_W-1:0] iss_cls_o,
  output logic [NUM_CLASSES-1:0]        rel_next_o,
  output logic [BW-1:0]                 busy_inc_o,
  output logic [NSLOT-1:0]              alloc_vld_o,
  output logic [NSLOT-1:0][SEQ_W-1:0]   alloc_seq_o,
  output logic [NSLOT-1:0][CLS_W-1:0]   alloc_cls_o,
  output logic [NSLOT-1:0][LAT_W-1:0]   alloc_wait_o,
  output logic [NSLOT-1:0]              alloc_unp_o
);
  int unsigned rank [NQ];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      rank[q] = 0;
      for (int r = 0; r < NQ; r++)
        if (r != q && head_vld_i[r] && head_seq_i[r] < head_seq_i[q]) rank[q]++;
    end
  end

  visit_e           act;
  logic             found, stop, got;
  int unsigned      sel, slot, left, nis, nbusy;
  logic [NSLOT-1:0] freem;

  always_comb begin
    pop_o        = '0;
    iss_seq_o    = '0;
    iss_cls_o    = '0;
    rel_next_o   = '0;
    alloc_vld_o  = '0;
    alloc_seq_o  = '0;
    alloc_cls_o  = '0;
    alloc_wait_o = '0;
    alloc_unp_o  = '0;
    freem = slot_free_i;
    left  = int'(budget_i);
    stop  = 1'b0;
    nis   = 0;
    nbusy = 0;
    act   = VIS_NONE;
    got   = 1'b0;
    slot  = 0;
    for (int p = 0; p < NQ; p++) begin
      found = 1'b0;
      sel   = 0;
      for (int q = 0; q < NQ; q++)
        if (head_vld_i[q] && rank[q] == p) begin
          found = 1'b1;
          sel   = q;
        end
      act = VIS_NONE;
      got = 1'b0;
      slot = 0;
      if (found && !stop) begin
        if (left == 0 || !can_issue_i) stop = 1'b1;
        else if (head_sq_i[sel]) act = VIS_DROP;
        else if (!free_ext_i[sel]) act = VIS_BUSY;
        else if (lat_ext_i[sel] <= LAT_W'(1)) act = VIS_ISSUE;
        else begin
          for (int s = 0; s < NSLOT; s++)
            if (freem[s] && !got) begin
              got  = 1'b1;
              slot = s;
            end
          act = got ? VIS_ISSUE : VIS_HOLD;
        end
      end
      case (act)
        VIS_DROP: pop_o[sel] = 1'b1;
        VIS_BUSY: nbusy++;
        VIS_ISSUE: begin
          pop_o[sel] = 1'b1;
          left--;
          if (got) begin
            freem[slot]        = 1'b0;
            alloc_vld_o[slot]  = 1'b1;
            alloc_seq_o[slot]  = head_seq_i[sel];
            alloc_cls_o[slot]  = CLS_W'(sel);
            alloc_wait_o[slot] = lat_ext_i[sel] - LAT_W'(2);
            alloc_unp_o[slot]  = unp_ext_i[sel];
          end else if (nis < ISSUE_W) begin
            iss_seq_o[nis] = head_seq_i[sel];
            iss_cls_o[nis] = CLS_W'(sel);
            nis++;
          end
          // pipelined or single-cycle units come back next cycle
          if (!(got && unp_ext_i[sel]))
            for (int c = 0; c < NUM_CLASSES; c++)
              if (c == sel) rel_next_o[c] = 1'b1;
        end
        default: ;
      endcase
    end
    iss_n_o    = LW'(nis);
    busy_inc_o = BW'(nbusy);
  end
endmodule

// File: rtl/issel_cpl.sv
module issel_cpl #(
  parameter int unsigned NUM_CLASSES = 3,
  parameter int unsigned CLS_W       = 2,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned LAT_W       = 3,
  parameter int unsigned NSLOT       = 4,
  parameter int unsigned LW          = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NSLOT-1:0]              alloc_vld_i,
  input  logic [NSLOT-1:0][SEQ_W-1:0]   alloc_seq_i,
  input  logic [NSLOT-1:0][CLS_W-1:0]   alloc_cls_i,
  input  logic [NSLOT-1:0][LAT_W-1:0]   alloc_wait_i,
  input  logic [NSLOT-1:0]              alloc_unp_i,
  output logic [NSLOT-1:0]              slot_free_o,
  output logic [LW-1:0]                 cpl_n_o,
  output logic [ISSUE_W-1:0][SEQ_W-1:0] cpl_seq_o,
  output logic [ISSUE_W-1:0][CLS_W-1:0] cpl_cls_o,
  output logic [NUM_CLASSES-1:0]        cpl_rel_o
);
  logic [NSLOT-1:0]            vld_q, unp_q, take;
  logic [NSLOT-1:0][LAT_W-1:0] tmr_q;
  logic [NSLOT-1:0][SEQ_W-1:0] seq_q;
  logic [NSLOT-1:0][CLS_W-1:0] cls_q;
  int unsigned                 n;

  assign slot_free_o = ~vld_q;

  // due slots leave in slot order, at most ISSUE_W per cycle
  always_comb begin
    take      = '0;
    cpl_seq_o = '0;
    cpl_cls_o = '0;
    cpl_rel_o = '0;
    n = 0;
    for (int s = 0; s < NSLOT; s++)
      if (vld_q[s] && tmr_q[s] == '0 && n < ISSUE_W) begin
        take[s]      = 1'b1;
        cpl_seq_o[n] = seq_q[s];
        cpl_cls_o[n] = cls_q[s];
        for (int c = 0; c < NUM_CLASSES; c++)
          if (unp_q[s] && int'(cls_q[s]) == c) cpl_rel_o[c] = 1'b1;
        n++;
      end
    cpl_n_o = LW'(n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      unp_q <= '0;
      tmr_q <= '0;
      seq_q <= '0;
      cls_q <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (take[s]) vld_q[s] <= 1'b0;
        else if (vld_q[s] && tmr_q[s] != '0) tmr_q[s] <= tmr_q[s] - LAT_W'(1);
        if (alloc_vld_i[s]) begin
          vld_q[s] <= 1'b1;
          tmr_q[s] <= alloc_wait_i[s];
          seq_q[s] <= alloc_seq_i[s];
          cls_q[s] <= alloc_cls_i[s];
          unp_q[s] <= alloc_unp_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/issue_selector.sv
module issue_selector #(
  parameter int unsigned NUM_CLASSES = 3,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned QDEPTH      = 4,
  parameter int unsigned ISSUE_W     = 2,
  parameter int unsigned LAT_W       = 3,
  parameter int unsigned NSLOT       = 4,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned NQ         = NUM_CLASSES + 1,
  localparam int unsigned CLS_W      = $clog2(NQ),
  localparam int unsigned LW         = $clog2(ISSUE_W + 1),
  localparam int unsigned BW         = $clog2(NQ + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_vld_i,
  input  logic [CLS_W-1:0]           push_cls_i,
  input  logic [SEQ_W-1:0]           push_seq_i,
  input  logic                       push_sq_i,
  input  logic [NUM_CLASSES-1:0]     unit_free_i,
  input  logic [NUM_CLASSES*LAT_W-1:0] op_lat_i,
  input  logic [NUM_CLASSES-1:0]     unpiped_i,
  input  logic                       can_issue_i,
  output logic [ISSUE_W-1:0]         exe_vld_o,
  output logic [ISSUE_W*SEQ_W-1:0]   exe_seq_o,
  output logic [ISSUE_W*CLS_W-1:0]   exe_cls_o,
  output logic [NUM_CLASSES*2-1:0]   unit_release_o,
  output logic [CNT_W-1:0]           busy_cnt_o
);
  logic [NQ-1:0]                 hv, hsq, pop, free_ext, unp_ext;
  logic [NQ-1:0][SEQ_W-1:0]      hseq;
  logic [NQ-1:0][LAT_W-1:0]      lat_ext;
  logic [NUM_CLASSES-1:0][LAT_W-1:0] lat_pk;
  logic [LW-1:0]                 iss_n, cpl_n, budget;
  logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq, cpl_seq;
  logic [ISSUE_W-1:0][CLS_W-1:0] iss_cls, cpl_cls;
  logic [NUM_CLASSES-1:0]        rel_next, rel_q, cpl_rel;
  logic [BW-1:0]                 busy_inc;
  logic [NSLOT-1:0]              slot_free, a_vld, a_unp;
  logic [NSLOT-1:0][SEQ_W-1:0]   a_seq;
  logic [NSLOT-1:0][CLS_W-1:0]   a_cls;
  logic [NSLOT-1:0][LAT_W-1:0]   a_wait;
  logic [CNT_W-1:0]              busy_q;

  assign lat_pk = op_lat_i;
  // the top class code needs no unit: always free, single cycle
  assign free_ext = {1'b1, unit_free_i};
  assign lat_ext  = {LAT_W'(1), lat_pk};
  assign unp_ext  = {1'b0, unpiped_i};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    issel_rdyq #(.SEQ_W(SEQ_W), .DEPTH(QDEPTH)) u_rdyq (
      .clk_i,
      .rst_ni,
      .push_i     (push_vld_i && push_cls_i == CLS_W'(q)),
      .push_seq_i,
      .push_sq_i,
      .pop_i      (pop[q]),
      .head_vld_o (hv[q]),
      .head_seq_o (hseq[q]),
      .head_sq_o  (hsq[q])
    );
  end

  assign budget = LW'(ISSUE_W) - cpl_n;

  issel_pick #(
    .NUM_CLASSES(NUM_CLASSES), .NQ(NQ), .CLS_W(CLS_W), .SEQ_W(SEQ_W),
    .ISSUE_W(ISSUE_W), .LAT_W(LAT_W), .NSLOT(NSLOT), .LW(LW), .BW(BW)
  ) u_pick (
    .head_vld_i  (hv),
    .head_seq_i  (hseq),
    .head_sq_i   (hsq),
    .free_ext_i  (free_ext),
    .lat_ext_i   (lat_ext),
    .unp_ext_i   (unp_ext),
    .can_issue_i,
    .budget_i    (budget),
    .slot_free_i (slot_free),
    .pop_o       (pop),
    .iss_n_o     (iss_n),
    .iss_seq_o   (iss_seq),
    .iss_cls_o   (iss_cls),
    .rel_next_o  (rel_next),
    .busy_inc_o  (busy_inc),
    .alloc_vld_o (a_vld),
    .alloc_seq_o (a_seq),
    .alloc_cls_o (a_cls),
    .alloc_wait_o(a_wait),
    .alloc_unp_o (a_unp)
  );

  issel_cpl #(
    .NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W), .SEQ_W(SEQ_W),
    .ISSUE_W(ISSUE_W), .LAT_W(LAT_W), .NSLOT(NSLOT), .LW(LW)
  ) u_cpl (
    .clk_i,
    .rst_ni,
    .alloc_vld_i (a_vld),
    .alloc_seq_i (a_seq),
    .alloc_cls_i (a_cls),
    .alloc_wait_i(a_wait),
    .alloc_unp_i (a_unp),
    .slot_free_o (slot_free),
    .cpl_n_o     (cpl_n),
    .cpl_seq_o   (cpl_seq),
    .cpl_cls_o   (cpl_cls),
    .cpl_rel_o   (cpl_rel)
  );

  // completions first, then same-cycle issues
  always_comb begin
    exe_vld_o = '0;
    exe_seq_o = '0;
    exe_cls_o = '0;
    for (int l = 0; l < ISSUE_W; l++) begin
      if (l < int'(cpl_n)) begin
        exe_vld_o[l]               = 1'b1;
        exe_seq_o[l*SEQ_W +: SEQ_W] = cpl_seq[l];
        exe_cls_o[l*CLS_W +: CLS_W] = cpl_cls[l];
      end else if (l - int'(cpl_n) < int'(iss_n)) begin
        exe_vld_o[l]               = 1'b1;
        exe_seq_o[l*SEQ_W +: SEQ_W] = iss_seq[l - int'(cpl_n)];
        exe_cls_o[l*CLS_W +: CLS_W] = iss_cls[l - int'(cpl_n)];
      end
    end
  end

  always_comb
    for (int c = 0; c < NUM_CLASSES; c++)
      unit_release_o[c*2 +: 2] = {1'b0, rel_q[c]} + {1'b0, cpl_rel[c]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q  <= '0;
      busy_q <= '0;
    end else begin
      rel_q  <= rel_next;
      busy_q <= busy_q + CNT_W'(busy_inc);
    end
  end

  assign busy_cnt_o = busy_q;
endmodule

// File: rtl/issue_selector_chk.sv
module issue_selector_chk #(
  parameter int unsigned ISSUE_W = 2,
  parameter int unsigned SEQ_W   = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LW      = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     can_issue_i,
  input logic [ISSUE_W-1:0]       exe_vld_o,
  input logic [ISSUE_W*SEQ_W-1:0] exe_seq_o,
  input logic [CNT_W-1:0]         busy_cnt_o,
  input logic [LW-1:0]            cpl_n
);
  // R10: lanes fill from lane 0 without gaps
  for (genvar l = 1; l < ISSUE_W; l++) begin : g_lane
    a_r10_lanes_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exe_vld_o[l] |-> exe_vld_o[l-1]);
    a_r2_issue_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exe_vld_o[l] && (l - 1) >= int'(cpl_n)) |->
        exe_seq_o[(l-1)*SEQ_W +: SEQ_W] < exe_seq_o[l*SEQ_W +: SEQ_W]);
  end

  a_r4_stall_only_cpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !can_issue_i |-> $countones(exe_vld_o) == int'(cpl_n));

  a_r6_no_busy_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !can_issue_i |=> busy_cnt_o == $past(busy_cnt_o));
endmodule

bind issue_selector issue_selector_chk #(
  .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .LW(LW)
) u_chk (.*);

// File: tb/issue_selector_bench.sv
module issue_selector_bench;
  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_vld = 1'b0;
  logic [1:0] push_cls = '0;
  logic [7:0] push_seq = '0;
  logic       push_sq = 1'b0;
  logic [2:0] unit_free = 3'b111;
  logic [8:0] op_lat = {3'd1, 3'd1, 3'd1};
  logic [2:0] unpiped = '0;
  logic       can_issue = 1'b0;
  logic [1:0] exe_vld;
  logic [15:0] exe_seq;
  logic [3:0] exe_cls;
  logic [5:0] unit_rel;
  logic [15:0] busy_cnt;

  int checks = 0;
  int fails = 0;

  always #(PER/2) clk = ~clk;

  issue_selector u_issue_selector (
    .clk_i(clk), .rst_ni, .push_vld_i(push_vld), .push_cls_i(push_cls),
    .push_seq_i(push_seq), .push_sq_i(push_sq), .unit_free_i(unit_free),
    .op_lat_i(op_lat), .unpiped_i(unpiped), .can_issue_i(can_issue),
    .exe_vld_o(exe_vld), .exe_seq_o(exe_seq), .exe_cls_o(exe_cls),
    .unit_release_o(unit_rel), .busy_cnt_o(busy_cnt)
  );

  // s0 s1 s2 free can lane0 lane1 busy_delta release_mask
  localparam int VEC [0:7][0:8] = '{
    '{ 10,  20,  30, 7, 1,  10,  20, 0, 3},
    '{ 30,  10,  20, 7, 1,  10,  20, 0, 6},
    '{  5,   6,   7, 6, 1,   6,   7, 1, 6},
    '{  5,   6,   7, 0, 1,  -1,  -1, 3, 0},
    '{  5,   6,   7, 7, 0,  -1,  -1, 0, 0},
    '{ 40,  41,  42, 5, 1,  40,  42, 1, 5},
    '{  9,   3, 200, 7, 1,   3,   9, 0, 3},
    '{100,   2,  50, 2, 1,   2,  -1, 2, 2}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lane(int l);
    return exe_vld[l] ? int'(exe_seq[l*8 +: 8]) : -1;
  endfunction

  function automatic int rel_exp(int mask);
    int r = 0;
    for (int c = 0; c < 3; c++) if (mask[c]) r |= 1 << (2*c);
    return r;
  endfunction

  task automatic drive(bit pv, int pc, int ps, bit psq, int fr, bit cn);
    @(negedge clk);
    push_vld  = pv;
    push_cls  = 2'(pc);
    push_seq  = 8'(ps);
    push_sq   = psq;
    unit_free = 3'(fr);
    can_issue = cn;
    #1;
  endtask

  task automatic push(int pc, int ps, bit psq);
    drive(1'b1, pc, ps, psq, 7, 1'b0);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) begin
      drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
      if (exe_vld == '0) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    int b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R1 reset lanes", int'(exe_vld), 0);
    chk("R1 reset release", int'(unit_rel), 0);
    chk("R1 reset busy", int'(busy_cnt), 0);

    // table: R2 ordering, R4 width/stall, R6 busy skip, R8 release
    for (int v = 0; v < 8; v++) begin
      push(0, VEC[v][0], 1'b0);
      push(1, VEC[v][1], 1'b0);
      push(2, VEC[v][2], 1'b0);
      b0 = int'(busy_cnt);
      drive(1'b0, 0, 0, 1'b0, VEC[v][3], VEC[v][4] != 0);
      chk($sformatf("R2 R4 vec%0d lane0", v), lane(0), VEC[v][5]);
      chk($sformatf("R2 R4 vec%0d lane1", v), lane(1), VEC[v][6]);
      drive(1'b0, 0, 0, 1'b0, 7, 1'b0);
      chk($sformatf("R6 vec%0d busy delta", v), int'(busy_cnt) - b0, VEC[v][7]);
      chk($sformatf("R8 vec%0d release", v), int'(unit_rel), rel_exp(VEC[v][8]));
      drain();
    end

    // R5: squashed head takes no lane
    push(0, 1, 1'b1);
    push(1, 2, 1'b0);
    push(2, 3, 1'b0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R5 lane0 after drop", lane(0), 2);
    chk("R5 lane1 after drop", lane(1), 3);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R5 dropped entry gone", int'(exe_vld), 0);

    // R3 R11: in-class ordering, one per class per cycle
    push(0, 50, 1'b0);
    push(0, 20, 1'b0);
    push(0, 35, 1'b0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R11 older push becomes head", lane(0), 20);
    chk("R3 one per class", lane(1), -1);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R3 second in class", lane(0), 35);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R3 third in class", lane(0), 50);

    // R7: no-unit class issues with every unit busy
    push(3, 8, 1'b0);
    drive(1'b0, 0, 0, 1'b0, 0, 1'b1);
    chk("R7 no-unit lane", lane(0), 8);
    chk("R7 no-unit class code", int'(exe_cls[1:0]), 3);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b0);
    chk("R7 no release", int'(unit_rel), 0);

    // R9 pipelined class 0, latency 3; R4 completion while stalled
    op_lat[2:0] = 3'd3;
    push(0, 60, 1'b0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R9 multi-cycle not on lane at issue", int'(exe_vld), 0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R9 pipelined release next cycle", int'(unit_rel), rel_exp(1));
    chk("R9 not yet complete", int'(exe_vld), 0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b0);
    chk("R9 R4 completion at L-1 while stalled", lane(0), 60);
    chk("R9 no release at completion", int'(unit_rel), 0);

    // R9 unpipelined class 1, latency 2
    op_lat[5:3] = 3'd2;
    unpiped[1] = 1'b1;
    push(1, 61, 1'b0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R9 unpiped no lane at issue", int'(exe_vld), 0);
    chk("R9 unpiped no early release", int'(unit_rel), 0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R9 unpiped completion", lane(0), 61);
    chk("R9 unpiped release at completion", int'(unit_rel), rel_exp(2));
    op_lat[5:3] = 3'd1;
    unpiped[1] = 1'b0;
    drive(1'b0, 0, 0, 1'b0, 7, 1'b0);

    // R10: completion takes lane 0 and shrinks the issue budget
    push(1, 71, 1'b0);
    push(2, 72, 1'b0);
    push(0, 70, 1'b0);
    b0 = int'(busy_cnt);
    drive(1'b0, 0, 0, 1'b0, 1, 1'b1);
    chk("R10 multi-cycle issue no lane", int'(exe_vld), 0);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b0);
    chk("R6 two skips counted", int'(busy_cnt) - b0, 2);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R10 completion in lane0", lane(0), 70);
    chk("R10 one issue left", lane(1), 71);
    drive(1'b0, 0, 0, 1'b0, 7, 1'b1);
    chk("R10 leftover next cycle", lane(0), 72);
    chk("R10 nothing else", lane(1), -1);
    op_lat[2:0] = 3'd1;

    finish_run();
  end
endmodule